// File: doc/BRIEF.md
# Host Bridge Control Register Decoder

This block sits behind a simple 32-bit register port with a 16-bit byte offset. It splits the offset space into windows and handles each one differently:

- A small bank of address-translation control words and a larger bank of bus control words are held locally and can be read back.
- The interrupt mapping windows and interrupt clear windows are not stored here. They are decoded into selects and strobes for an external interrupt dispatcher, which returns mapping contents on a read-data input.
- A reset control and status word combines write-one-to-clear cause bits with soft reset request bits. Setting a soft request bit raises a system reset request pulse toward the reset sequencer.

Diagnostic, error and unlisted offsets swallow writes and read as zero. Read data is registered and appears one cycle after the read strobe.

A power-up reset (`rst_ni`) puts every register in its initial state and marks the power-on cause in the reset status word. A warm reset (`warm_rst_i`) clears the translation and bus control banks but leaves the reset status word as it was. Only the first reset after power-up therefore records a power-on cause.

Top module: `hbc_ctrl_regs`

## Requirements
- R1: After `rst_ni` is released, `rdata_o`, `xlat_o` and `bus_o` are zero, no strobe or reset request is active, and the reset status word reads 0x80000000.
- R2: Offsets 0x200..0x20B hold three translation words selected by offset bits 3:2. Writes update the selected word on `xlat_o`, and reads return it.
- R3: Writes to offsets 0x20C..0x3FF pulse `flush_o` in the same cycle, change no register, and read back as zero.
- R4: Offsets 0x2000..0x202F hold twelve bus control words selected by offset bits 5:2. Writes update the selected word on `bus_o`, and reads return it.
- R5: An access to 0xC00..0xC3F drives `map_sel_o` = {1'b0, 2'b00, offset[5:3]}. An access to 0x1000..0x10FF drives `map_sel_o` = {1'b1, offset[7:3]}. Writes there also raise `map_we_o` in the same cycle. Reads there return the `map_rdata_i` value present during the read strobe. Outside these windows `map_sel_o` is zero.
- R6: A write to 0x1400..0x14FF raises exactly bit offset[7:5] of `pci_clr_o` in that cycle. Reads raise no bit.
- R7: A write to 0x1800..0x1860 raises exactly bit offset[7:3] (0..12) of `io_clr_o` in that cycle. Reads raise no bit.
- R8: The reset status word sits at 0xF020..0xF027. Bits 31, 28 and 27 are cleared where the written bit is 1. Bits 30 and 29 are set where the written bit is 1 and are otherwise kept. All other bits read 0.
- R9: A write to the reset status word with bit 30 or bit 29 set gives a one-cycle `rst_req_o` pulse in the next cycle. `rst_kind_o` is 1 when bit 30 was set (soft power-on) and 0 when only bit 29 was set (soft externally-initiated).
- R10: A cycle with `warm_rst_i` high clears all translation and bus control words by the next cycle and leaves the reset status word unchanged.
- R11: Offsets 0x30..0x4F, 0x5000..0x51CF, 0xA400..0xA67F, 0xA800..0xA80F, 0xF000..0xF01F and all unlisted offsets ignore writes and read as zero.
- R12: `rdata_o` takes the read value on the clock edge that ends a read strobe cycle and holds it through every cycle without a read strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous power-up reset |
| warm_rst_i | input | 1 | Synchronous warm reset of the control banks |
| req_i | input | 1 | Access strobe, one access per cycle |
| we_i | input | 1 | 1 = write, 0 = read |
| addr_i | input | 16 | Byte offset |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Registered read data |
| xlat_o | output | 3x32 | Translation control words |
| bus_o | output | 12x32 | Bus control words |
| flush_o | output | 1 | Translation flush strobe |
| map_sel_o | output | 6 | Interrupt mapping select {group, index} |
| map_we_o | output | 1 | Interrupt mapping write strobe (data on wdata_i) |
| map_rdata_i | input | 32 | Mapping contents for the current select |
| pci_clr_o | output | 8 | One-hot PCI interrupt group clear strobes |
| io_clr_o | output | 13 | One-hot I/O interrupt clear strobes |
| rst_req_o | output | 1 | System reset request pulse |
| rst_kind_o | output | 1 | Reset kind: 1 power-on, 0 externally-initiated |

## Verification
The two kinds of state fault show up differently. A wrong bank word or reset status bit stays hidden until that word is read, and then it surfaces on `rdata_o` one cycle later; for the two banks it is also visible at once on `xlat_o` or `bus_o`. A mis-decoded window is visible in the same cycle, as a wrong or missing strobe on `flush_o`, `map_sel_o`, `pci_clr_o` or `io_clr_o`. A wrong reset-word update rule is visible either as a wrong `rst_req_o` or `rst_kind_o` in the following cycle, or on the next read of 0xF020.

// File: rtl/hbc_pkg.sv
package hbc_pkg;
  localparam int DATA_W = 32;
  localparam int ADDR_W = 16;

  typedef enum logic [3:0] {
    WIN_NONE, WIN_QUIET, WIN_XLAT, WIN_FLUSH, WIN_PMAP,
    WIN_IMAP, WIN_PCLR, WIN_ICLR, WIN_BUS, WIN_RST
  } win_e;

  localparam logic [DATA_W-1:0] RST_W1C_MASK  = 32'h9800_0000;
  localparam logic [DATA_W-1:0] RST_SET_MASK  = 32'h6000_0000;
  localparam logic [DATA_W-1:0] RST_PWRUP_VAL = 32'h8000_0000;
  localparam int SOFT_PWR_BIT = 30;
  localparam int SOFT_EXT_BIT = 29;

  function automatic logic in_win(logic [ADDR_W-1:0] a, logic [ADDR_W-1:0] lo,
                                  logic [ADDR_W-1:0] hi);
    return (a >= lo) && (a <= hi);
  endfunction
endpackage

// File: rtl/hbc_addr_dec.sv
module hbc_addr_dec
  import hbc_pkg::*;
#(
  parameter int IDX_W = 5
) (
  input  logic [ADDR_W-1:0] addr_i,
  output win_e              win_o,
  output logic [IDX_W-1:0]  idx_o
);
  always_comb begin
    win_o = WIN_NONE;
    idx_o = '0;
    if (in_win(addr_i, 16'h0030, 16'h004F) || in_win(addr_i, 16'h5000, 16'h51CF) ||
        in_win(addr_i, 16'hA400, 16'hA67F) || in_win(addr_i, 16'hA800, 16'hA80F) ||
        in_win(addr_i, 16'hF000, 16'hF01F)) begin
      win_o = WIN_QUIET;
    end else if (in_win(addr_i, 16'h0200, 16'h020B)) begin
      win_o = WIN_XLAT;
      idx_o = IDX_W'(addr_i[3:2]);
    end else if (in_win(addr_i, 16'h020C, 16'h03FF)) begin
      win_o = WIN_FLUSH;
    end else if (in_win(addr_i, 16'h0C00, 16'h0C3F)) begin
      win_o = WIN_PMAP;
      idx_o = IDX_W'(addr_i[5:3]);
    end else if (in_win(addr_i, 16'h1000, 16'h10FF)) begin
      win_o = WIN_IMAP;
      idx_o = IDX_W'(addr_i[7:3]);
    end else if (in_win(addr_i, 16'h1400, 16'h14FF)) begin
      win_o = WIN_PCLR;
      idx_o = IDX_W'(addr_i[7:5]);
    end else if (in_win(addr_i, 16'h1800, 16'h1860)) begin
      win_o = WIN_ICLR;
      idx_o = IDX_W'(addr_i[7:3]);
    end else if (in_win(addr_i, 16'h2000, 16'h202F)) begin
      win_o = WIN_BUS;
      idx_o = IDX_W'(addr_i[5:2]);
    end else if (in_win(addr_i, 16'hF020, 16'hF027)) begin
      win_o = WIN_RST;
    end
  end
endmodule

// File: rtl/hbc_word_bank.sv
module hbc_word_bank
  import hbc_pkg::*;
#(
  parameter int N  = 3,
  parameter int IW = 2
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic                       clr_i,
  input  logic                       we_i,
  input  logic [IW-1:0]              idx_i,
  input  logic [DATA_W-1:0]          wdata_i,
  output logic [N-1:0][DATA_W-1:0]   words_o
);
  logic [N-1:0][DATA_W-1:0] words_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      words_q <= '0;
    end else if (clr_i) begin
      words_q <= '0;
    end else if (we_i) begin
      for (int i = 0; i < N; i++) begin
        if (idx_i == IW'(i)) words_q[i] <= wdata_i;
      end
    end
  end

  for (genvar g = 0; g < N; g++) begin : g_out
    assign words_o[g] = words_q[g];
  end
endmodule

// File: rtl/hbc_rst_stat.sv
module hbc_rst_stat
  import hbc_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] stat_o,
  output logic              req_o,
  output logic              kind_o
);
  logic soft_hit;
  assign soft_hit = we_i && (wdata_i[SOFT_PWR_BIT] || wdata_i[SOFT_EXT_BIT]);

  // power-up only: warm reset is deliberately not wired here
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      stat_o <= RST_PWRUP_VAL;
      req_o  <= 1'b0;
      kind_o <= 1'b0;
    end else begin
      req_o <= soft_hit;
      if (soft_hit) kind_o <= wdata_i[SOFT_PWR_BIT];
      if (we_i) stat_o <= (stat_o & ~(wdata_i & RST_W1C_MASK)) | (wdata_i & RST_SET_MASK);
    end
  end
endmodule

// File: rtl/hbc_ctrl_regs.sv
module hbc_ctrl_regs
  import hbc_pkg::*;
#(
  parameter int XLAT_N = 3,
  parameter int BUS_N  = 12,
  parameter int IMAP_N = 32,
  parameter int PCLR_N = 8,
  parameter int ICLR_N = 13,
  localparam int IDX_W = $clog2(IMAP_N),
  localparam int SEL_W = IDX_W + 1
) (
  input  logic                          clk_i,
  input  logic                          rst_ni,
  input  logic                          warm_rst_i,
  input  logic                          req_i,
  input  logic                          we_i,
  input  logic [15:0]                   addr_i,
  input  logic [31:0]                   wdata_i,
  output logic [31:0]                   rdata_o,
  output logic [XLAT_N-1:0][31:0]       xlat_o,
  output logic [BUS_N-1:0][31:0]        bus_o,
  output logic                          flush_o,
  output logic [SEL_W-1:0]              map_sel_o,
  output logic                          map_we_o,
  input  logic [31:0]                   map_rdata_i,
  output logic [PCLR_N-1:0]             pci_clr_o,
  output logic [ICLR_N-1:0]             io_clr_o,
  output logic                          rst_req_o,
  output logic                          rst_kind_o
);
  localparam int XI_W = $clog2(XLAT_N);
  localparam int BI_W = $clog2(BUS_N);

  win_e              win;
  logic [IDX_W-1:0]  idx;
  logic              wr, rd;
  logic [31:0]       rst_stat, rd_next, rdata_q;

  hbc_addr_dec #(.IDX_W(IDX_W)) u_dec (
    .addr_i (addr_i),
    .win_o  (win),
    .idx_o  (idx)
  );

  assign wr = req_i && we_i;
  assign rd = req_i && !we_i;

  hbc_word_bank #(.N(XLAT_N), .IW(XI_W)) u_xlat (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .clr_i   (warm_rst_i),
    .we_i    (wr && (win == WIN_XLAT)),
    .idx_i   (idx[XI_W-1:0]),
    .wdata_i (wdata_i),
    .words_o (xlat_o)
  );

  hbc_word_bank #(.N(BUS_N), .IW(BI_W)) u_bus (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .clr_i   (warm_rst_i),
    .we_i    (wr && (win == WIN_BUS)),
    .idx_i   (idx[BI_W-1:0]),
    .wdata_i (wdata_i),
    .words_o (bus_o)
  );

  hbc_rst_stat u_rst (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .we_i    (wr && (win == WIN_RST)),
    .wdata_i (wdata_i),
    .stat_o  (rst_stat),
    .req_o   (rst_req_o),
    .kind_o  (rst_kind_o)
  );

  assign flush_o  = wr && (win == WIN_FLUSH);
  assign map_we_o = wr && ((win == WIN_PMAP) || (win == WIN_IMAP));

  always_comb begin
    map_sel_o = '0;
    if (req_i && (win == WIN_PMAP)) map_sel_o = {1'b0, idx};
    else if (req_i && (win == WIN_IMAP)) map_sel_o = {1'b1, idx};
  end

  for (genvar g = 0; g < PCLR_N; g++) begin : g_pclr
    assign pci_clr_o[g] = wr && (win == WIN_PCLR) && (idx == IDX_W'(g));
  end

  for (genvar g = 0; g < ICLR_N; g++) begin : g_iclr
    assign io_clr_o[g] = wr && (win == WIN_ICLR) && (idx == IDX_W'(g));
  end

  always_comb begin
    rd_next = '0;
    unique case (win)
      WIN_XLAT: if (idx < IDX_W'(XLAT_N)) rd_next = xlat_o[idx[XI_W-1:0]];
      WIN_BUS:  if (idx < IDX_W'(BUS_N)) rd_next = bus_o[idx[BI_W-1:0]];
      WIN_PMAP, WIN_IMAP: rd_next = map_rdata_i;
      WIN_RST:  rd_next = rst_stat;
      default:  rd_next = '0;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) rdata_q <= '0;
    else if (rd) rdata_q <= rd_next;
  end

  assign rdata_o = rdata_q;
endmodule

// File: rtl/hbc_ctrl_regs_chk.sv
module hbc_ctrl_regs_chk #(
  parameter int XLAT_N = 3,
  parameter int BUS_N  = 12,
  parameter int PCLR_N = 8,
  parameter int ICLR_N = 13
) (
  input logic                    clk_i,
  input logic                    rst_ni,
  input logic                    warm_rst_i,
  input logic                    req_i,
  input logic                    we_i,
  input logic [15:0]             addr_i,
  input logic [1:0]              soft_bits,
  input logic [31:0]             rdata_o,
  input logic [XLAT_N-1:0][31:0] xlat_o,
  input logic [BUS_N-1:0][31:0]  bus_o,
  input logic                    flush_o,
  input logic                    map_we_o,
  input logic [PCLR_N-1:0]       pci_clr_o,
  input logic [ICLR_N-1:0]       io_clr_o,
  input logic                    rst_req_o,
  input logic                    rst_kind_o
);
  logic rst_hit;
  assign rst_hit = req_i && we_i && (addr_i >= 16'hF020) && (addr_i <= 16'hF027);

  AST_RST_REQ_CAUSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rst_req_o |-> $past(rst_hit && (soft_bits != 2'b00)));  // R9

  AST_RST_KIND: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rst_req_o |-> (rst_kind_o == $past(soft_bits[1])));  // R9

  AST_PCLR_ONEHOT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(pci_clr_o));  // R6

  AST_ICLR_ONEHOT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(io_clr_o));  // R7

  AST_STROBE_ON_WRITE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (flush_o || map_we_o || (|pci_clr_o) || (|io_clr_o)) |-> (req_i && we_i));  // R3

  AST_RDATA_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$past(req_i && !we_i) |-> $stable(rdata_o));  // R12

  AST_WARM_CLEAR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    warm_rst_i |=> ((xlat_o == '0) && (bus_o == '0)));  // R10
endmodule

bind hbc_ctrl_regs hbc_ctrl_regs_chk #(
  .XLAT_N(XLAT_N), .BUS_N(BUS_N), .PCLR_N(PCLR_N), .ICLR_N(ICLR_N)
) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .warm_rst_i (warm_rst_i),
  .req_i      (req_i),
  .we_i       (we_i),
  .addr_i     (addr_i),
  .soft_bits  (wdata_i[30:29]),
  .rdata_o    (rdata_o),
  .xlat_o     (xlat_o),
  .bus_o      (bus_o),
  .flush_o    (flush_o),
  .map_we_o   (map_we_o),
  .pci_clr_o  (pci_clr_o),
  .io_clr_o   (io_clr_o),
  .rst_req_o  (rst_req_o),
  .rst_kind_o (rst_kind_o)
);

// File: tb/hbc_ctrl_regs_bench.sv
`timescale 1ns/1ps
module hbc_ctrl_regs_bench;
  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              warm = 1'b0;
  logic              req = 1'b0;
  logic              we = 1'b0;
  logic [15:0]       addr = '0;
  logic [31:0]       wdata = '0;
  logic [31:0]       rdata;
  logic [2:0][31:0]  xlat;
  logic [11:0][31:0] bus;
  logic              flush;
  logic [5:0]        map_sel;
  logic              map_we;
  logic [31:0]       map_rdata;
  logic [7:0]        pclr;
  logic [12:0]       iclr;
  logic              rst_req;
  logic              rst_kind;

  int errors = 0;
  int checks = 0;
  bit done = 0;

  logic [31:0] xlat_m [3];
  logic [31:0] bus_m [12];
  logic [31:0] rst_m;
  logic [31:0] last_rd;

  always #2.5 clk = ~clk;

  assign map_rdata = 32'hC0DE_0000 | {26'd0, map_sel};

  hbc_ctrl_regs u_hbc_ctrl_regs (
    .clk_i(clk), .rst_ni(rst_n), .warm_rst_i(warm), .req_i(req), .we_i(we),
    .addr_i(addr), .wdata_i(wdata), .rdata_o(rdata), .xlat_o(xlat), .bus_o(bus),
    .flush_o(flush), .map_sel_o(map_sel), .map_we_o(map_we), .map_rdata_i(map_rdata),
    .pci_clr_o(pclr), .io_clr_o(iclr), .rst_req_o(rst_req), .rst_kind_o(rst_kind)
  );

  task automatic check(bit ok, string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h t=%0t", tag, act, exp, $time);
    end
  endtask

  // 0 none,1 quiet,2 xlat,3 flush,4 pci map,5 io map,6 pci clr,7 io clr,8 bus,9 reset word
  function automatic int region(logic [15:0] a);
    if ((a >= 16'h0030 && a <= 16'h004F) || (a >= 16'h5000 && a <= 16'h51CF) ||
        (a >= 16'hA400 && a <= 16'hA67F) || (a >= 16'hA800 && a <= 16'hA80F) ||
        (a >= 16'hF000 && a <= 16'hF01F)) return 1;
    if (a >= 16'h0200 && a <= 16'h020B) return 2;
    if (a >= 16'h020C && a <= 16'h03FF) return 3;
    if (a >= 16'h0C00 && a <= 16'h0C3F) return 4;
    if (a >= 16'h1000 && a <= 16'h10FF) return 5;
    if (a >= 16'h1400 && a <= 16'h14FF) return 6;
    if (a >= 16'h1800 && a <= 16'h1860) return 7;
    if (a >= 16'h2000 && a <= 16'h202F) return 8;
    if (a >= 16'hF020 && a <= 16'hF027) return 9;
    return 0;
  endfunction

  function automatic string rtag(int r);
    case (r)
      2: return "R2";
      3: return "R3";
      4, 5: return "R5";
      8: return "R4";
      9: return "R8";
      default: return "R11";
    endcase
  endfunction

  function automatic logic [31:0] exp_rd(logic [15:0] a);
    case (region(a))
      2: return xlat_m[a[3:2]];
      4: return 32'hC0DE_0000 | {29'd0, a[5:3]};
      5: return 32'hC0DE_0000 | 32'd32 | {27'd0, a[7:3]};
      8: return bus_m[a[5:2]];
      9: return rst_m;
      default: return 32'd0;
    endcase
  endfunction

  function automatic logic [5:0] exp_sel(logic [15:0] a);
    case (region(a))
      4: return {3'b000, a[5:3]};
      5: return {1'b1, a[7:3]};
      default: return 6'd0;
    endcase
  endfunction

  function automatic logic [15:0] rand_addr(int k);
    logic [15:0] a;
    case (k)
      1: case ($urandom % 5)
           0: a = 16'h0030 + 16'($urandom % 32);
           1: a = 16'h5000 + 16'($urandom % 464);
           2: a = 16'hA400 + 16'($urandom % 640);
           3: a = 16'hA800 + 16'($urandom % 16);
           default: a = 16'hF000 + 16'($urandom % 32);
         endcase
      2: a = 16'h0200 + 16'($urandom % 12);
      3: a = 16'h020C + 16'($urandom % 500);
      4: a = 16'h0C00 + 16'($urandom % 64);
      5: a = 16'h1000 + 16'($urandom % 256);
      6: a = 16'h1400 + 16'($urandom % 256);
      7: a = 16'h1800 + 16'(8 * ($urandom % 13));
      8: a = 16'h2000 + 16'($urandom % 48);
      9: a = 16'hF020 + 16'($urandom % 8);
      default: case ($urandom % 8)
           0: a = 16'h0000;
           1: a = 16'h0100;
           2: a = 16'h0C40;
           3: a = 16'h1868;
           4: a = 16'h2030;
           5: a = 16'h8000;
           6: a = 16'hF028;
           default: a = 16'hFFFC;
         endcase
    endcase
    return a;
  endfunction

  task automatic op(bit w, logic [15:0] a, logic [31:0] d);
    int r;
    logic [31:0] e_pclr, e_iclr;
    r = region(a);
    e_pclr = (w && r == 6) ? (32'd1 << a[7:5]) : 32'd0;
    e_iclr = (w && r == 7) ? (32'd1 << a[7:3]) : 32'd0;
    @(negedge clk);
    req = 1'b1; we = w; addr = a; wdata = d;
    #1;
    check(flush == (w && r == 3), "R3 flush strobe", {31'd0, flush}, {31'd0, w && r == 3});
    check(map_sel == exp_sel(a), "R5 map select", {26'd0, map_sel}, {26'd0, exp_sel(a)});
    check(map_we == (w && (r == 4 || r == 5)), "R5 map write strobe", {31'd0, map_we},
          {31'd0, w && (r == 4 || r == 5)});
    check({24'd0, pclr} == e_pclr, "R6 pci clear strobe", {24'd0, pclr}, e_pclr);
    check({19'd0, iclr} == e_iclr, "R7 io clear strobe", {19'd0, iclr}, e_iclr);
    @(posedge clk);
    #1;
    req = 1'b0;
    if (!w) begin
      check(rdata == exp_rd(a), {rtag(r), " read R12"}, rdata, exp_rd(a));
      last_rd = exp_rd(a);
    end else begin
      check(rdata == last_rd, "R12 hold on write", rdata, last_rd);
      check(rst_req == (r == 9 && (d[30] || d[29])), "R9 reset request", {31'd0, rst_req},
            {31'd0, r == 9 && (d[30] || d[29])});
      if (r == 9 && (d[30] || d[29]))
        check(rst_kind == d[30], "R9 reset kind", {31'd0, rst_kind}, {31'd0, d[30]});
      case (r)
        2: xlat_m[a[3:2]] = d;
        8: bus_m[a[5:2]] = d;
        9: rst_m = (rst_m & ~(d & 32'h9800_0000)) | (d & 32'h6000_0000);
        default: ;
      endcase
      if (r == 2) check(xlat[a[3:2]] == xlat_m[a[3:2]], "R2 xlat word", xlat[a[3:2]], xlat_m[a[3:2]]);
      if (r == 8) check(bus[a[5:2]] == bus_m[a[5:2]], "R4 bus word", bus[a[5:2]], bus_m[a[5:2]]);
    end
  endtask

  task automatic check_banks(string tag);
    for (int i = 0; i < 3; i++) check(xlat[i] == xlat_m[i], tag, xlat[i], xlat_m[i]);
    for (int i = 0; i < 12; i++) check(bus[i] == bus_m[i], tag, bus[i], bus_m[i]);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240));
    for (int i = 0; i < 3; i++) xlat_m[i] = '0;
    for (int i = 0; i < 12; i++) bus_m[i] = '0;
    rst_m = 32'h8000_0000;
    last_rd = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #1;
    // R1 reset state
    check(rdata == 32'd0, "R1 rdata after reset", rdata, 32'd0);
    check(rst_req == 1'b0, "R1 no reset request", {31'd0, rst_req}, 32'd0);
    check(pclr == '0 && iclr == '0 && !flush && !map_we, "R1 strobes idle",
          {19'd0, iclr}, 32'd0);
    check_banks("R1 banks zero");
    op(1'b0, 16'hF020, '0);

    // R2 R4 boundary words
    op(1'b1, 16'h0208, 32'hA5A5_0002);
    op(1'b0, 16'h020B, '0);
    op(1'b1, 16'h202C, 32'h1234_000B);
    op(1'b0, 16'h202F, '0);
    op(1'b1, 16'h2000, 32'hFEED_0000);
    // R3 flush edges
    op(1'b1, 16'h020C, 32'hFFFF_FFFF);
    op(1'b1, 16'h03FF, 32'hFFFF_FFFF);
    op(1'b0, 16'h020C, '0);
    // R5 map edges
    op(1'b1, 16'h10F8, 32'h8000_0001);
    op(1'b0, 16'h0C38, '0);
    op(1'b0, 16'h1000, '0);
    // R6 R7 clear edges
    op(1'b1, 16'h14E0, '0);
    op(1'b1, 16'h1860, '0);
    op(1'b1, 16'h1868, '0);
    op(1'b0, 16'h1400, '0);
    // R8 R9 reset word
    op(1'b1, 16'hF020, 32'hFFFF_FFFF);
    op(1'b0, 16'hF024, '0);
    op(1'b1, 16'hF020, 32'h2000_0000);
    op(1'b1, 16'hF020, 32'h0000_0000);
    op(1'b0, 16'hF020, '0);
    // R11 quiet and unmapped
    op(1'b1, 16'h0030, 32'hFFFF_FFFF);
    op(1'b1, 16'hF01F, 32'hFFFF_FFFF);
    op(1'b1, 16'h2030, 32'hFFFF_FFFF);
    op(1'b0, 16'hA80F, '0);
    check_banks("R11 banks untouched");

    // R10 warm reset
    op(1'b1, 16'h0204, 32'h0BAD_CAFE);
    @(negedge clk);
    warm = 1'b1;
    @(posedge clk);
    #1;
    warm = 1'b0;
    for (int i = 0; i < 3; i++) xlat_m[i] = '0;
    for (int i = 0; i < 12; i++) bus_m[i] = '0;
    check_banks("R10 warm clears banks");
    op(1'b0, 16'hF020, '0);

    for (int n = 0; n < 800; n++) begin
      op(($urandom % 2) == 1, rand_addr(int'($urandom % 10)), $urandom);
    end
    check_banks("R2 R4 final banks");

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule